// File: doc/BRIEF.md
# Soft-Start and Fault Latch Sequencer

This block is the digital sequencer for a multi-rail regulator. It holds every rail off until the bias supply, the 5 V auxiliary supply and the 3.3 V auxiliary supply all report good. It then runs a soft-start ramp, modelled as a counter. The ramp first jumps to a preset level, about a quarter of full scale. After that it climbs one step per programmable number of clocks until it reaches its top code. Only then does the block report that start-up is complete.

The block also handles faults. An over-current event, or an undervoltage on a linear rail once the ramp is complete, starts a hiccup retry. The rails are inhibited, the ramp is run down at its own discharge rate, and a fresh soft-start follows. Each retry is counted, and the third one latches a fault. An over-voltage event latches the fault at once. A latched fault turns off all rails and raises the fault output. Removing the bias supply is the only thing that clears the fault latch and the retry count. Losing an auxiliary supply, or asserting shutdown, stops the rails and clears the ramp. A new soft-start begins when the condition goes away.

Top module: `ssfault_seq`

## Requirements
- R1: After reset, `rails_en`, `ss_done` and `fault_out` are 0 and `ramp` is 0. No soft-start begins unless `bias_ok`, `aux5_ok` and `aux33_ok` are all 1 and `shutdown_req` is 0.
- R2: When start-up begins, `rails_en` rises one clock after the start condition is first sampled. On the clock after that, `ramp` takes the value PRESET_VAL (default 256 of a 1023 full scale).
- R3: From PRESET_VAL the ramp rises by one every CHG_DIV clocks until it reaches 2^RAMP_W−1. One clock later `ss_done` becomes 1 and the ramp holds at full scale.
- R4: A pulse on `ov_evt` while `bias_ok` is 1 sets `fault_out` on the next clock from any state. After that, `rails_en` and `ss_done` are 0 and the ramp is cleared. When `ov_evt` and `oc_evt` arrive in the same clock, the result is the over-voltage fault.
- R5: An `oc_evt` pulse while `ss_done` is 1 drops `rails_en` and `ss_done`. The ramp then falls by one every DIS_DIV clocks to 0, and a new soft-start follows.
- R6: An `oc_evt` pulse during the ramp drops `rails_en`, but the ramp keeps rising to full scale. It then discharges without ever raising `ss_done`. Further `oc_evt` pulses during that same inhibited ramp are not counted.
- R7: The RETRY_LIMIT-th counted over-current (default the third) latches the fault instead of retrying.
- R8: `luv_flag` has no effect while `ss_done` is 0. While `ss_done` is 1, it acts exactly like `oc_evt`.
- R9: Once `fault_out` is 1, it stays 1 through auxiliary supply loss and shutdown. Only `bias_ok` at 0 clears `fault_out` and the retry count.
- R10: `shutdown_req` at 1, or `aux5_ok` or `aux33_ok` at 0, after start-up clears `rails_en` and `ss_done` on the next clock and clears `ramp` one clock later. The retry count is kept, and removing the condition starts a new soft-start from PRESET_VAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on threshold; 0 clears everything |
| aux5_ok | input | 1 | 5 V auxiliary supply above its threshold |
| aux33_ok | input | 1 | 3.3 V auxiliary supply above its threshold |
| shutdown_req | input | 1 | External request holding the ramp low |
| oc_evt | input | 1 | Single-cycle over-current event |
| ov_evt | input | 1 | Single-cycle over-voltage event |
| luv_flag | input | 1 | Linear-rail undervoltage flag |
| rails_en | output | 1 | Output enable for all rails (inhibit when 0) |
| ramp | output | RAMP_W | Soft-start ramp value |
| ss_done | output | 1 | Ramp complete, rails in regulation |
| fault_out | output | 1 | Latched fault |

## Verification
The bench goes after the timing of the ramp. A design with the prescaler off by one, or one that skipped the preset, would reach full scale at the wrong clock or load the wrong first value.

It also goes after how retries are counted:
- A design that counted every over-current pulse during an inhibited ramp, instead of one per retry, would latch the fault a retry early.
- A design that honoured undervoltage during the ramp would also latch early.
- A design that stopped the ramp on an over-current during start-up would never reach full scale before discharging.

Finally, the bench checks two fault corners. A design that let supply loss or shutdown clear the latch or the count would release the fault or miss the third retry. A design that gave over-current priority over a same-clock over-voltage would retry instead of faulting.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

   typedef enum logic [5:0] {
      ST_IDLE   = 6'b000001,
      ST_PRESET = 6'b000010,
      ST_CHARGE = 6'b000100,
      ST_RUN    = 6'b001000,
      ST_DISCH  = 6'b010000,
      ST_FAULT  = 6'b100000
   } ssf_state_e;

   // counter width able to hold values 0 .. n-1
   function automatic int unsigned ssf_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ssf_prescale.sv
module ssf_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   import ssf_pkg::*;

   localparam int unsigned CW = ssf_cnt_w(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/ssf_ramp.sv
module ssf_ramp #(
   parameter int unsigned RAMP_W     = 10,
   parameter int unsigned PRESET_VAL = 256,
   parameter int unsigned CHG_DIV    = 4,
   parameter int unsigned DIS_DIV    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              charge,
   input  logic              discharge,
   output logic [RAMP_W-1:0] ramp,
   output logic              full,
   output logic              empty
);
   localparam logic [RAMP_W-1:0] TOP  = {RAMP_W{1'b1}};
   localparam logic [RAMP_W-1:0] LOADV = RAMP_W'(PRESET_VAL);

   logic chg_tick;
   logic dis_tick;
   logic [RAMP_W-1:0] ramp_q;

   ssf_prescale #(.DIV(CHG_DIV)) u_chg_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (charge),
      .tick (chg_tick)
   );

   ssf_prescale #(.DIV(DIS_DIV)) u_dis_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (discharge),
      .tick (dis_tick)
   );

   assign full  = (ramp_q == TOP);
   assign empty = (ramp_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ramp_q <= '0;
      else if (clr)                ramp_q <= '0;
      else if (load)               ramp_q <= LOADV;
      else if (chg_tick && !full)  ramp_q <= ramp_q + 1'b1;
      else if (dis_tick && !empty) ramp_q <= ramp_q - 1'b1;
   end

   assign ramp = ramp_q;

endmodule

// File: rtl/ssf_retry.sv
module ssf_retry #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);
   import ssf_pkg::*;

   localparam int unsigned CW = ssf_cnt_w(LIMIT);
   localparam logic [CW-1:0] FINAL = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (clr)                     cnt_q <= '0;
      else if (bump && cnt_q != FINAL)  cnt_q <= cnt_q + 1'b1;
   end

   // next counted event is the one that must latch the fault
   assign last = (cnt_q == FINAL);

endmodule

// File: rtl/ssfault_seq.sv
module ssfault_seq #(
   parameter int unsigned RAMP_W      = 10,
   parameter int unsigned PRESET_VAL  = 256,
   parameter int unsigned CHG_DIV     = 4,
   parameter int unsigned DIS_DIV     = 2,
   parameter int unsigned RETRY_LIMIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bias_ok,
   input  logic              aux5_ok,
   input  logic              aux33_ok,
   input  logic              shutdown_req,
   input  logic              oc_evt,
   input  logic              ov_evt,
   input  logic              luv_flag,
   output logic              rails_en,
   output logic [RAMP_W-1:0] ramp,
   output logic              ss_done,
   output logic              fault_out
);
   import ssf_pkg::*;

   generate
      if (RAMP_W < 2) begin : g_bad_width
         $error("ssfault_seq: RAMP_W must be at least 2");
      end
      if (PRESET_VAL == 0 || PRESET_VAL >= (1 << RAMP_W) - 1) begin : g_bad_preset
         $error("ssfault_seq: PRESET_VAL must lie strictly inside the ramp range");
      end
      if (CHG_DIV < 1 || DIS_DIV < 1) begin : g_bad_div
         $error("ssfault_seq: prescaler divisors must be at least 1");
      end
      if (RETRY_LIMIT < 1) begin : g_bad_limit
         $error("ssfault_seq: RETRY_LIMIT must be at least 1");
      end
   endgenerate

   ssf_state_e state_q, state_d;
   logic inh_q, inh_d;
   logic bump;
   logic last_try;
   logic ramp_full, ramp_empty;
   logic go;
   logic ramp_evt;
   logic run_evt;

   assign go       = bias_ok && aux5_ok && aux33_ok && !shutdown_req;
   // over-current during the ramp counts once per retry
   assign ramp_evt = oc_evt && !inh_q;
   // undervoltage only honoured once the ramp is complete
   assign run_evt  = oc_evt || luv_flag;

   ssf_ramp #(
      .RAMP_W    (RAMP_W),
      .PRESET_VAL(PRESET_VAL),
      .CHG_DIV   (CHG_DIV),
      .DIS_DIV   (DIS_DIV)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!bias_ok || state_q == ST_IDLE || state_q == ST_FAULT),
      .load     (state_q == ST_PRESET),
      .charge   (state_q == ST_CHARGE),
      .discharge(state_q == ST_DISCH),
      .ramp     (ramp),
      .full     (ramp_full),
      .empty    (ramp_empty)
   );

   ssf_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!bias_ok),
      .bump (bump),
      .last (last_try)
   );

   always_comb begin
      state_d = state_q;
      inh_d   = inh_q;
      bump    = 1'b0;
      if (!bias_ok) begin
         state_d = ST_IDLE;
         inh_d   = 1'b0;
      end else if (ov_evt) begin
         state_d = ST_FAULT;
      end else if (state_q == ST_FAULT) begin
         state_d = ST_FAULT;
      end else if (state_q != ST_IDLE && !go) begin
         state_d = ST_IDLE;
         inh_d   = 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               inh_d = 1'b0;
               if (go) state_d = ST_PRESET;
            end
            ST_PRESET: begin
               state_d = ST_CHARGE;
               if (ramp_evt) begin
                  bump = 1'b1;
                  if (last_try) state_d = ST_FAULT;
                  else          inh_d   = 1'b1;
               end
            end
            ST_CHARGE: begin
               if (ramp_evt && last_try) begin
                  bump    = 1'b1;
                  state_d = ST_FAULT;
               end else begin
                  if (ramp_evt) begin
                     bump  = 1'b1;
                     inh_d = 1'b1;
                  end
                  if (ramp_full)
                     state_d = (inh_q || ramp_evt) ? ST_DISCH : ST_RUN;
               end
            end
            ST_RUN: begin
               if (run_evt) begin
                  bump    = 1'b1;
                  state_d = last_try ? ST_FAULT : ST_DISCH;
               end
            end
            ST_DISCH: begin
               if (ramp_empty) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         inh_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         inh_q   <= inh_d;
      end
   end

   assign rails_en  = (state_q == ST_PRESET) ||
                      (state_q == ST_CHARGE && !inh_q) ||
                      (state_q == ST_RUN);
   assign ss_done   = (state_q == ST_RUN);
   assign fault_out = (state_q == ST_FAULT);

endmodule

// File: rtl/ssfault_seq_chk.sv
module ssfault_seq_chk #(
   parameter int unsigned RAMP_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bias_ok,
   input logic              aux5_ok,
   input logic              aux33_ok,
   input logic              shutdown_req,
   input logic              ov_evt,
   input logic              rails_en,
   input logic [RAMP_W-1:0] ramp,
   input logic              ss_done,
   input logic              fault_out
);
   localparam logic [RAMP_W-1:0] TOP = {RAMP_W{1'b1}};

   a_r1_start_needs_supplies: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rails_en) |-> $past(bias_ok && aux5_ok && aux33_ok && !shutdown_req));

   a_r3_done_at_full: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done |-> (ramp == TOP));

   a_r3_done_follows_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_done) |-> ($past(ramp) == TOP));

   a_r4_ov_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_evt && bias_ok) |=> fault_out);

   a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fault_out |-> (!rails_en && !ss_done));

   a_r9_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_out && bias_ok) |=> fault_out);

   a_r10_loss_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (!bias_ok || !aux5_ok || !aux33_ok || shutdown_req) |=> (!rails_en && !ss_done));

endmodule

bind ssfault_seq ssfault_seq_chk #(.RAMP_W(RAMP_W)) u_ssfault_seq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bias_ok     (bias_ok),
   .aux5_ok     (aux5_ok),
   .aux33_ok    (aux33_ok),
   .shutdown_req(shutdown_req),
   .ov_evt      (ov_evt),
   .rails_en    (rails_en),
   .ramp        (ramp),
   .ss_done     (ss_done),
   .fault_out   (fault_out)
);

// File: tb/ssfault_seq_bench.sv
module ssfault_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int RW    = 6;
   localparam int PRE   = 16;
   localparam int CDIV  = 3;
   localparam int DDIV  = 2;
   localparam int LIMIT = 3;
   localparam int TOPV  = (1 << RW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bias_ok = 1'b0, aux5_ok = 1'b0, aux33_ok = 1'b0, shutdown_req = 1'b0;
   logic oc_evt = 1'b0, ov_evt = 1'b0, luv_flag = 1'b0;
   logic rails_en, ss_done, fault_out;
   logic [RW-1:0] ramp;

   int tests = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssfault_seq #(
      .RAMP_W(RW), .PRESET_VAL(PRE), .CHG_DIV(CDIV), .DIS_DIV(DDIV), .RETRY_LIMIT(LIMIT)
   ) u_ssfault_seq (
      .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .aux5_ok(aux5_ok), .aux33_ok(aux33_ok),
      .shutdown_req(shutdown_req), .oc_evt(oc_evt), .ov_evt(ov_evt), .luv_flag(luv_flag),
      .rails_en(rails_en), .ramp(ramp), .ss_done(ss_done), .fault_out(fault_out)
   );

   function automatic int exp_charge_clocks();
      return (TOPV - PRE) * CDIV;
   endfunction

   function automatic int exp_dis_clocks();
      return TOPV * DDIV;
   endfunction

   function automatic bit exp_fault(input int counted);
      return counted >= LIMIT;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
      tests++;
      if (act < lo || act > hi) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!ss_done && cyc < 2000) begin
         tick(1);
         cyc++;
      end
   endtask

   task automatic wait_en(output int cyc);
      cyc = 0;
      while (!rails_en && cyc < 2000) begin
         tick(1);
         cyc++;
      end
   endtask

   task automatic pulse_oc();  oc_evt = 1'b1;   tick(1); oc_evt = 1'b0;   endtask
   task automatic pulse_luv(); luv_flag = 1'b1; tick(1); luv_flag = 1'b0; endtask
   task automatic bias_cycle(); bias_ok = 1'b0; tick(2); bias_ok = 1'b1; endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int cyc;
      int r0;
      int maxr;
      bit seen_done;
      void'($urandom(32'h5eed_0a11));

      // R1 reset state
      tick(3);
      rst_n = 1'b1;
      tick(2);
      check_eq("R1", "rails_en after reset", rails_en, 0);
      check_eq("R1", "ramp after reset", ramp, 0);
      check_eq("R1", "ss_done after reset", ss_done, 0);
      check_eq("R1", "fault after reset", fault_out, 0);

      // R1 one supply missing, then shutdown held
      bias_ok = 1'b1; aux5_ok = 1'b1;
      tick(20);
      check_eq("R1", "no start without 3.3V", rails_en, 0);
      shutdown_req = 1'b1; aux33_ok = 1'b1;
      tick(20);
      check_eq("R1", "no start under shutdown", rails_en, 0);

      // R2 preset
      shutdown_req = 1'b0;
      tick(1);
      check_eq("R2", "rails_en one clock after start", rails_en, 1);
      tick(1);
      check_eq("R2", "ramp preset value", ramp, PRE);

      // R8 undervoltage ignored during ramp
      tick(10);
      pulse_luv();
      tick(2);
      check_eq("R8", "rails_en after luv during ramp", rails_en, 1);

      // R3 charge timing
      wait_done(cyc);
      check_rng("R3", "clocks to done", cyc + 13, exp_charge_clocks(), exp_charge_clocks() + 3);
      check_eq("R3", "ramp at full", ramp, TOPV);
      check_eq("R8", "no fault after blanked luv", fault_out, 0);

      // R5 over-current in run -> hiccup (count 1)
      pulse_oc();
      tick(1);
      check_eq("R5", "rails_en after oc", rails_en, 0);
      check_eq("R5", "ss_done after oc", ss_done, 0);
      wait_en(cyc);
      check_rng("R5", "discharge clocks", cyc, exp_dis_clocks() - 2, exp_dis_clocks() + 4);
      tick(1);
      check_eq("R5", "restart preset", ramp, PRE);

      // R6 over-current during ramp (count 2), second pulse ignored
      tick(15);
      pulse_oc();
      tick(1);
      check_eq("R6", "rails_en inhibited", rails_en, 0);
      r0 = ramp;
      tick(12);
      check_rng("R6", "ramp keeps charging", ramp, r0 + 2, TOPV);
      pulse_oc();
      maxr = 0; seen_done = 0; cyc = 0;
      while (ramp != 0 && cyc < 2000) begin
         if (ramp > maxr) maxr = ramp;
         if (ss_done) seen_done = 1;
         tick(1);
         cyc++;
      end
      check_eq("R6", "ramp reached full while inhibited", maxr, TOPV);
      check_eq("R6", "no done while inhibited", seen_done, 0);
      check_eq("R6", "extra pulse not counted", fault_out, 0);

      // R10 shutdown mid-ramp, count kept
      wait_en(cyc);
      tick(10);
      shutdown_req = 1'b1;
      tick(1);
      check_eq("R10", "rails_en after shutdown", rails_en, 0);
      tick(1);
      check_eq("R10", "ramp cleared by shutdown", ramp, 0);
      shutdown_req = 1'b0;
      tick(2);
      check_eq("R10", "restart preset", ramp, PRE);
      aux33_ok = 1'b0;
      tick(2);
      check_eq("R10", "ramp cleared by supply loss", ramp, 0);
      check_eq("R10", "rails off on supply loss", rails_en, 0);
      aux33_ok = 1'b1;
      wait_done(cyc);

      // R7 / R8 third counted event via undervoltage in run
      pulse_luv();
      tick(2);
      check_eq("R7", "fault on third event", fault_out, 1);
      check_eq("R7", "rails off in fault", rails_en, 0);

      // R9 fault survives aux loss and shutdown
      aux5_ok = 1'b0; shutdown_req = 1'b1;
      tick(10);
      aux5_ok = 1'b1; shutdown_req = 1'b0;
      tick(10);
      check_eq("R9", "fault held", fault_out, 1);
      check_eq("R9", "ramp stays 0 in fault", ramp, 0);
      bias_cycle();
      tick(1);
      check_eq("R9", "fault cleared by bias", fault_out, 0);

      // R4 ov and oc in same clock during ramp
      tick(8);
      oc_evt = 1'b1; ov_evt = 1'b1;
      tick(1);
      oc_evt = 1'b0; ov_evt = 1'b0;
      tick(2);
      check_eq("R4", "ov wins over oc", fault_out, 1);
      check_eq("R4", "ramp cleared", ramp, 0);
      check_eq("R4", "rails off", rails_en, 0);
      bias_cycle();

      // R9 count cleared: two events, no fault
      wait_done(cyc); pulse_oc();
      wait_done(cyc); pulse_oc();
      tick(3);
      check_eq("R9", "count cleared by bias", fault_out, 0);

      // R7 / R8 random retry sequences
      for (int it = 0; it < 6; it++) begin
         int n;
         int c;
         bias_cycle();
         n = $urandom_range(0, 4);
         c = 0;
         for (int j = 0; j < n; j++) begin
            if (c >= LIMIT) break;
            if ($urandom_range(0, 1) == 1) pulse_luv();
            wait_done(cyc);
            if ($urandom_range(0, 1) == 1) pulse_oc();
            else                           pulse_luv();
            c++;
            tick(3);
         end
         check_eq("R7", "fault after random retries", fault_out, exp_fault(c));
      end

      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule